// File: doc/BRIEF.md
# Dual-Clock Job Stack

A per-core job store that sits between a processor and the load-balancing network of a manycore chip. The processor side runs on its own clock and pushes or pops 32-bit job words, one operation per cycle. A job that does not fit in 32 bits is kept in main memory, and its pointer is stored in the entry instead. The network side runs on an unrelated clock. It can remove the top job for an outbound transfer, or insert an inbound job as the new top. The block also exports its current occupancy as a register in the network clock, so that the balancing comparators can read it every network cycle.

Storage and the stack pointer belong to the processor domain. A network request crosses into that domain through a toggle handshake. It is serviced on a processor cycle that carries no processor operation, and its result crosses back the same way. The occupancy reaches the network domain as a Gray-coded pointer through a two-flop synchronizer. A job the processor has already popped has left the store, so the network can never move it. Only jobs still waiting can be taken.

Top module: `jstk_top`

## Requirements
- R1: The store is last-in-first-out on 32-bit entries: a pop returns the job pushed most recently among those still held, whichever side inserted it.
- R2: A processor push with room stores `cpu_wdata` and raises `cpu_count` by one on the next cycle, with `cpu_rvalid` low. A processor pop on a non-empty store gives `cpu_rvalid`=1, `cpu_rdata`=top job and `cpu_count` lowered by one on the next cycle.
- R3: After reset, `cpu_count` and `net_count` are 0, and `cpu_rvalid`, `cpu_err`, `net_busy`, `net_done` and `net_full` are all low.
- R4: A processor pop while the store is empty is refused. `cpu_err` is 1 for one cycle, `cpu_rvalid` stays 0 and the count stays 0.
- R5: A processor push while `cpu_count` equals DEPTH (default 16) is refused with `cpu_err` for one cycle. The count and the held jobs are unchanged.
- R6: Push and pop asserted in the same processor cycle are both refused with `cpu_err`, and the count is unchanged.
- R7: Processor operations always complete in one cycle. A pending network request is served only on a processor cycle with neither push nor pop, so a run of back-to-back processor operations holds it off until the run ends.
- R8: `net_count` is a network-clock register that follows the occupancy and settles to `cpu_count` within six network cycles of the last change. `net_full` is 1 exactly when `net_count` equals DEPTH.
- R9: When `net_busy` is low, a one-cycle `net_take` starts a removal. `net_busy` then stays high until `net_done` pulses for one network cycle. If the store held a job, `net_ok`=1 and `net_rdata` is the removed top job. Otherwise `net_ok`=0 and nothing changes.
- R10: A one-cycle `net_give` while idle inserts `net_wdata` as the new top and reports `net_ok`=1 with `net_done`. If the store is full it reports `net_ok`=0 and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| cpu_push | input | 1 | Push `cpu_wdata` this cycle |
| cpu_pop | input | 1 | Pop the top job this cycle |
| cpu_wdata | input | 32 | Job word to push |
| cpu_rdata | output | 32 | Popped job word, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | One-cycle pulse, pop delivered a job |
| cpu_err | output | 1 | One-cycle pulse, operation refused |
| cpu_count | output | clog2(DEPTH+1) | Occupancy in the processor domain |
| net_clk | input | 1 | Network-side clock |
| net_rst | input | 1 | Synchronous active-high reset, network domain |
| net_take | input | 1 | Request removal of the top job |
| net_give | input | 1 | Request insertion of `net_wdata` |
| net_wdata | input | 32 | Inbound job word |
| net_busy | output | 1 | A network request is outstanding |
| net_done | output | 1 | One-cycle pulse, request finished |
| net_ok | output | 1 | Result of the finished request, valid with `net_done` |
| net_rdata | output | 32 | Removed job word, valid with `net_done` and `net_ok` |
| net_count | output | clog2(DEPTH+1) | Synchronized occupancy for the balancer |
| net_full | output | 1 | Store cannot accept an inbound job |

## Verification
The bench targets the ends of the range. It pops from an empty store, pushes into a full one, and asks the network to take from an empty store or give to a full one. A design that wrapped its pointer would report a count of zero or 31, or hand back stale data, where the refusal flag should rise. A hold-off scenario keeps the processor pushing while a network insertion is pending. A design that let the network in during the run would bury the inbound job below the later pushes, so the first pop after the run would not return it. The bench also waits for the exported count to settle after a fill, to catch a broken crossing that never shows the full value.

// File: rtl/jstk_pkg.sv
package jstk_pkg;

    localparam int JOB_W = 32;

    typedef logic [JOB_W-1:0] job_t;

    typedef enum logic [1:0] {
        NOP_NONE = 2'd0,
        NOP_TAKE = 2'd1,
        NOP_GIVE = 2'd2
    } net_op_e;

    typedef struct packed {
        net_op_e op;
        job_t    data;
    } net_req_t;

    typedef struct packed {
        logic ok;
        job_t data;
    } net_rsp_t;

    typedef enum logic [2:0] {
        ACT_IDLE     = 3'd0,
        ACT_CPU_POP  = 3'd1,
        ACT_CPU_PUSH = 3'd2,
        ACT_CPU_BAD  = 3'd3,
        ACT_NET_TAKE = 3'd4,
        ACT_NET_GIVE = 3'd5,
        ACT_NET_DENY = 3'd6
    } act_e;

endpackage

// File: rtl/jstk_sync.sv
module jstk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/jstk_gray_xing.sv
module jstk_gray_xing #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] src_gray;
    logic [W-1:0] dst_chain [STAGES];
    logic [W-1:0] dst_dec;

    // Source side: register the Gray image so only one bit moves per step.
    always_ff @(posedge src_clk) begin
        if (src_rst) src_gray <= '0;
        else         src_gray <= src_bin ^ (src_bin >> 1);
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge dst_clk) begin
                    if (dst_rst) dst_chain[0] <= '0;
                    else         dst_chain[0] <= src_gray;
                end
            end else begin : g_next
                always_ff @(posedge dst_clk) begin
                    if (dst_rst) dst_chain[s] <= '0;
                    else         dst_chain[s] <= dst_chain[s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < W; i++) begin
            dst_dec[i] = ^(dst_chain[STAGES-1] >> i);
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) dst_bin <= '0;
        else         dst_bin <= dst_dec;
    end
endmodule

// File: rtl/jstk_core.sv
module jstk_core
    import jstk_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  job_t          wdata,
    output job_t          rdata,
    output logic          rvalid,
    output logic          err,
    output logic [CW-1:0] count,
    input  logic          req_tgl_s,
    input  net_req_t      req,
    output logic          ack_tgl,
    output net_rsp_t      rsp
);
    job_t          mem [DEPTH];
    logic [CW-1:0] ptr;
    logic [CW-1:0] top_c;
    logic [AW-1:0] top_idx;
    logic [AW-1:0] free_idx;
    logic          empty;
    logic          full;
    logic          pending;
    act_e          act;

    assign top_c    = ptr - 1'b1;
    assign top_idx  = top_c[AW-1:0];
    assign free_idx = ptr[AW-1:0];
    assign empty    = (ptr == '0);
    assign full     = (ptr == CW'(DEPTH));
    assign pending  = (req_tgl_s != ack_tgl);
    assign count    = ptr;

    // Processor operations win; the network only uses idle processor cycles.
    always_comb begin
        act = ACT_IDLE;
        if (push && pop)                          act = ACT_CPU_BAD;
        else if (pop)                             act = empty ? ACT_CPU_BAD : ACT_CPU_POP;
        else if (push)                            act = full  ? ACT_CPU_BAD : ACT_CPU_PUSH;
        else if (pending && req.op == NOP_TAKE)   act = empty ? ACT_NET_DENY : ACT_NET_TAKE;
        else if (pending && req.op == NOP_GIVE)   act = full  ? ACT_NET_DENY : ACT_NET_GIVE;
        else if (pending)                         act = ACT_NET_DENY;
    end

    always_ff @(posedge clk) begin
        if (act == ACT_CPU_PUSH)      mem[free_idx] <= wdata;
        else if (act == ACT_NET_GIVE) mem[free_idx] <= req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            rdata   <= '0;
            rvalid  <= 1'b0;
            err     <= 1'b0;
            ack_tgl <= 1'b0;
            rsp     <= '0;
        end else begin
            rvalid <= 1'b0;
            err    <= 1'b0;
            case (act)
                ACT_CPU_POP: begin
                    rdata  <= mem[top_idx];
                    rvalid <= 1'b1;
                    ptr    <= top_c;
                end
                ACT_CPU_PUSH: ptr <= ptr + 1'b1;
                ACT_CPU_BAD:  err <= 1'b1;
                ACT_NET_TAKE: begin
                    rsp     <= '{ok: 1'b1, data: mem[top_idx]};
                    ptr     <= top_c;
                    ack_tgl <= ~ack_tgl;
                end
                ACT_NET_GIVE: begin
                    rsp     <= '{ok: 1'b1, data: '0};
                    ptr     <= ptr + 1'b1;
                    ack_tgl <= ~ack_tgl;
                end
                ACT_NET_DENY: begin
                    rsp     <= '{ok: 1'b0, data: '0};
                    ack_tgl <= ~ack_tgl;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/jstk_net_port.sv
module jstk_net_port
    import jstk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic     give,
    input  job_t     wdata,
    input  logic     ack_tgl_s,
    input  net_rsp_t rsp,
    output logic     req_tgl,
    output net_req_t req,
    output logic     busy,
    output logic     done,
    output logic     ok,
    output job_t     rdata
);
    logic ack_seen;

    assign busy = (req_tgl != ack_seen);

    // Request fields stay frozen while busy, so the far side samples them safely.
    always_ff @(posedge clk) begin
        if (rst) begin
            req_tgl <= 1'b0;
            req     <= '{op: NOP_NONE, data: '0};
        end else if (!busy && (take || give)) begin
            req_tgl <= ~req_tgl;
            req     <= '{op: (take ? NOP_TAKE : NOP_GIVE), data: wdata};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_seen <= 1'b0;
            done     <= 1'b0;
            ok       <= 1'b0;
            rdata    <= '0;
        end else if (ack_tgl_s != ack_seen) begin
            ack_seen <= ack_tgl_s;
            done     <= 1'b1;
            ok       <= rsp.ok;
            rdata    <= rsp.data;
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/jstk_top.sv
module jstk_top
    import jstk_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          cpu_clk,
    input  logic          cpu_rst,
    input  logic          cpu_push,
    input  logic          cpu_pop,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic          cpu_rvalid,
    output logic          cpu_err,
    output logic [CW-1:0] cpu_count,
    input  logic          net_clk,
    input  logic          net_rst,
    input  logic          net_take,
    input  logic          net_give,
    input  logic [31:0]   net_wdata,
    output logic          net_busy,
    output logic          net_done,
    output logic          net_ok,
    output logic [31:0]   net_rdata,
    output logic [CW-1:0] net_count,
    output logic          net_full
);
    logic     req_tgl;
    logic     req_tgl_s;
    logic     ack_tgl;
    logic     ack_tgl_s;
    net_req_t req;
    net_rsp_t rsp;

    jstk_core #(.DEPTH(DEPTH)) u_core (
        .clk      (cpu_clk),
        .rst      (cpu_rst),
        .push     (cpu_push),
        .pop      (cpu_pop),
        .wdata    (cpu_wdata),
        .rdata    (cpu_rdata),
        .rvalid   (cpu_rvalid),
        .err      (cpu_err),
        .count    (cpu_count),
        .req_tgl_s(req_tgl_s),
        .req      (req),
        .ack_tgl  (ack_tgl),
        .rsp      (rsp)
    );

    jstk_sync #(.STAGES(2)) u_req_sync (
        .clk(cpu_clk), .rst(cpu_rst), .d(req_tgl), .q(req_tgl_s)
    );

    jstk_sync #(.STAGES(2)) u_ack_sync (
        .clk(net_clk), .rst(net_rst), .d(ack_tgl), .q(ack_tgl_s)
    );

    jstk_gray_xing #(.W(CW), .STAGES(2)) u_cnt_xing (
        .src_clk(cpu_clk),
        .src_rst(cpu_rst),
        .src_bin(cpu_count),
        .dst_clk(net_clk),
        .dst_rst(net_rst),
        .dst_bin(net_count)
    );

    jstk_net_port u_net (
        .clk      (net_clk),
        .rst      (net_rst),
        .take     (net_take),
        .give     (net_give),
        .wdata    (net_wdata),
        .ack_tgl_s(ack_tgl_s),
        .rsp      (rsp),
        .req_tgl  (req_tgl),
        .req      (req),
        .busy     (net_busy),
        .done     (net_done),
        .ok       (net_ok),
        .rdata    (net_rdata)
    );

    assign net_full = (net_count == CW'(DEPTH));
endmodule

// File: rtl/jstk_chk.sv
module jstk_chk #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          cpu_clk,
    input logic          cpu_rst,
    input logic          cpu_push,
    input logic          cpu_pop,
    input logic          cpu_rvalid,
    input logic          cpu_err,
    input logic [CW-1:0] cpu_count,
    input logic          net_clk,
    input logic          net_rst,
    input logic          net_done,
    input logic [CW-1:0] net_count
);
    assert_pop_ok_R2: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (cpu_pop && !cpu_push && cpu_count != '0)
        |=> (cpu_rvalid && cpu_count + 1'b1 == $past(cpu_count)));

    assert_pop_empty_R4: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (cpu_pop && !cpu_push && cpu_count == '0)
        |=> (cpu_err && !cpu_rvalid && cpu_count == '0));

    assert_no_overflow_R5: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (cpu_push && !cpu_pop && cpu_count == CW'(DEPTH))
        |=> (cpu_err && cpu_count == CW'(DEPTH)));

    assert_both_refused_R6: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (cpu_push && cpu_pop) |=> (cpu_err && $stable(cpu_count)));

    assert_cpu_first_R7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        (cpu_push ^ cpu_pop)
        |=> (cpu_rvalid || cpu_err || cpu_count != $past(cpu_count)));

    assert_step_R2: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
        1'b1 |=> (cpu_count == $past(cpu_count) ||
                  cpu_count == $past(cpu_count) + 1'b1 ||
                  cpu_count + 1'b1 == $past(cpu_count)));

    assert_net_bound_R8: assert property (@(posedge net_clk) disable iff (net_rst)
        net_count <= CW'(DEPTH));

    assert_done_pulse_R9: assert property (@(posedge net_clk) disable iff (net_rst)
        net_done |=> !net_done);
endmodule

bind jstk_top jstk_chk #(.DEPTH(DEPTH)) u_chk (
    .cpu_clk   (cpu_clk),
    .cpu_rst   (cpu_rst),
    .cpu_push  (cpu_push),
    .cpu_pop   (cpu_pop),
    .cpu_rvalid(cpu_rvalid),
    .cpu_err   (cpu_err),
    .cpu_count (cpu_count),
    .net_clk   (net_clk),
    .net_rst   (net_rst),
    .net_done  (net_done),
    .net_count (net_count)
);

// File: tb/sim_jstk_top.sv
module sim_jstk_top;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          cpu_clk = 1'b0;
    logic          cpu_rst = 1'b1;
    logic          cpu_push = 1'b0;
    logic          cpu_pop = 1'b0;
    logic [31:0]   cpu_wdata = '0;
    logic [31:0]   cpu_rdata;
    logic          cpu_rvalid;
    logic          cpu_err;
    logic [CW-1:0] cpu_count;
    logic          net_clk = 1'b0;
    logic          net_rst = 1'b1;
    logic          net_take = 1'b0;
    logic          net_give = 1'b0;
    logic [31:0]   net_wdata = '0;
    logic          net_busy;
    logic          net_done;
    logic          net_ok;
    logic [31:0]   net_rdata;
    logic [CW-1:0] net_count;
    logic          net_full;

    int checks = 0;
    int errors = 0;

    always #10 cpu_clk = ~cpu_clk;
    always #16 net_clk = ~net_clk;

    jstk_top #(.DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input bit good, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [31:0] d);
        @(negedge cpu_clk); cpu_push = 1'b1; cpu_wdata = d;
        @(negedge cpu_clk); cpu_push = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge cpu_clk); cpu_pop = 1'b1;
        @(negedge cpu_clk); cpu_pop = 1'b0;
    endtask

    task automatic pop_expect(input logic [31:0] exp, input string tag);
        do_pop();
        chk(cpu_rvalid && cpu_rdata == exp, tag, cpu_rdata, exp);
    endtask

    task automatic settle();
        repeat (6) @(negedge net_clk);
    endtask

    task automatic drain();
        while (cpu_count != '0) do_pop();
        settle();
    endtask

    task automatic net_req(input bit take, input logic [31:0] d,
                           output bit ok, output logic [31:0] rd, output bit busy_seen);
        @(negedge net_clk); net_take = take; net_give = !take; net_wdata = d;
        @(negedge net_clk); net_take = 1'b0; net_give = 1'b0;
        busy_seen = net_busy;
        ok = 1'b0; rd = '0;
        for (int i = 0; i < 40; i++) begin
            if (net_done) begin ok = net_ok; rd = net_rdata; break; end
            @(negedge net_clk);
        end
        chk(net_done, "R9 done pulse seen", {31'd0, net_done}, 32'd1);
    endtask

    task automatic t_reset();
        chk(cpu_count == '0 && net_count == '0, "R3 counts after reset",
            {cpu_count, net_count}, 32'd0);
        chk(!cpu_rvalid && !cpu_err && !net_busy && !net_done && !net_full,
            "R3 flags after reset",
            {cpu_rvalid, cpu_err, net_busy, net_done, net_full}, 32'd0);
    endtask

    task automatic t_lifo();
        do_push(32'hA1);
        chk(!cpu_rvalid && cpu_count == 1, "R2 push count", cpu_count, 32'd1);
        do_push(32'hB2);
        do_push(32'hC3);
        pop_expect(32'hC3, "R1 pop newest");
        chk(cpu_count == 2, "R2 pop count", cpu_count, 32'd2);
        pop_expect(32'hB2, "R1 pop middle");
        pop_expect(32'hA1, "R1 pop oldest");
    endtask

    task automatic t_pop_empty();
        do_pop();
        chk(cpu_err && !cpu_rvalid, "R4 pop empty err", {cpu_err, cpu_rvalid}, 32'h2);
        chk(cpu_count == '0, "R4 count stays zero", cpu_count, 32'd0);
    endtask

    task automatic t_both();
        do_push(32'h55);
        @(negedge cpu_clk); cpu_push = 1'b1; cpu_pop = 1'b1; cpu_wdata = 32'h66;
        @(negedge cpu_clk); cpu_push = 1'b0; cpu_pop = 1'b0;
        chk(cpu_err && cpu_count == 1, "R6 push+pop refused", cpu_count, 32'd1);
        pop_expect(32'h55, "R6 contents intact");
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) do_push(32'h100 + i);
        do_push(32'hDEAD);
        chk(cpu_err && cpu_count == CW'(DEPTH), "R5 push full refused",
            cpu_count, DEPTH);
        settle();
        chk(net_count == CW'(DEPTH) && net_full, "R8 net count full",
            net_count, DEPTH);
    endtask

    task automatic t_give_full();
        bit ok; logic [31:0] rd; bit b;
        net_req(1'b0, 32'hBEEF, ok, rd, b);
        chk(!ok && cpu_count == CW'(DEPTH), "R10 give to full refused",
            {31'd0, ok}, 32'd0);
        pop_expect(32'h100 + DEPTH - 1, "R5 top unchanged after refusals");
        settle();
        chk(!net_full && net_count == CW'(DEPTH - 1), "R8 net count after pop",
            net_count, DEPTH - 1);
        drain();
        chk(net_count == '0, "R8 net count drained", net_count, 32'd0);
    endtask

    task automatic t_take();
        bit ok; logic [31:0] rd; bit b;
        do_push(32'h11);
        do_push(32'h22);
        net_req(1'b1, 32'h0, ok, rd, b);
        chk(b, "R9 busy after take", {31'd0, b}, 32'd1);
        chk(ok && rd == 32'h22, "R9 take returns top", rd, 32'h22);
        chk(cpu_count == 1, "R9 count after take", cpu_count, 32'd1);
        pop_expect(32'h11, "R1 after network take");
    endtask

    task automatic t_take_empty();
        bit ok; logic [31:0] rd; bit b;
        net_req(1'b1, 32'h0, ok, rd, b);
        chk(!ok && cpu_count == '0, "R9 take empty refused", {31'd0, ok}, 32'd0);
    endtask

    task automatic t_give();
        bit ok; logic [31:0] rd; bit b;
        do_push(32'h77);
        net_req(1'b0, 32'h99, ok, rd, b);
        chk(ok && cpu_count == 2, "R10 give accepted", cpu_count, 32'd2);
        pop_expect(32'h99, "R10 given job on top");
        pop_expect(32'h77, "R1 below given job");
    endtask

    task automatic t_priority();
        bit busy_end;
        fork
            begin
                for (int i = 0; i < 8; i++) begin
                    @(negedge cpu_clk); cpu_push = 1'b1; cpu_wdata = 32'h300 + i;
                end
                @(negedge cpu_clk); cpu_push = 1'b0;
                busy_end = net_busy;
            end
            begin
                @(negedge cpu_clk); @(negedge cpu_clk);
                @(negedge net_clk); net_give = 1'b1; net_wdata = 32'hF00D;
                @(negedge net_clk); net_give = 1'b0;
            end
        join
        chk(busy_end, "R7 network waits during processor run", {31'd0, busy_end}, 32'd1);
        for (int i = 0; i < 40 && net_busy; i++) @(negedge net_clk);
        chk(!net_busy && net_ok, "R7 held request completes", {31'd0, net_ok}, 32'd1);
        pop_expect(32'hF00D, "R7 inbound job above processor run");
        pop_expect(32'h307, "R7 last processor job next");
        drain();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge net_clk);
        @(negedge cpu_clk); cpu_rst = 1'b0;
        @(negedge net_clk); net_rst = 1'b0;
        repeat (2) @(negedge net_clk);
        t_reset();
        t_lifo();
        t_pop_empty();
        t_both();
        t_full();
        t_give_full();
        t_take();
        t_take_empty();
        t_give();
        drain();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule